// File: doc/BRIEF.md
# DRAM Strobe Mode Decoder

This block sits on the device side of an asynchronous DRAM interface. It samples the row strobe, the upper and lower column strobes, write enable and output enable on a fast system clock. It works out which kind of memory cycle each row-strobe low period carried and reports that as a mode code when the row strobe returns high. While a cycle runs, it gives a write pulse and an output-drive enable for each byte lane. It also raises one-sample violation flags when the strobes break the interface's ordering rules.

The two column strobes are treated as one combined strobe when the cycle is classified. The combined strobe turns active on whichever line falls first and turns inactive only when both lines are high again. Write pulses and output enables still follow each byte's own strobe. The block fits a controller testbench as a passive checker, or a memory model as a front-end decoder.

Top module: `dram_mode_decoder`

## Requirements
- R1: While reset is held, and on the first sample after it, mode is 0 (standby), and mode_valid, wr_stb, oe_en, self_ref and viol are all zero.
- R2: A row strobe fall while either column strobe is low gives a refresh cycle with the column strobe first. It reports mode 6 when the row strobe has been sampled low for fewer than SELF_SAMPLES samples, and it produces no write pulse.
- R3: A row strobe low period with no column strobe fall reports mode 5 (row-only refresh).
- R4: One combined column pulse with write enable held high reports mode 1 (read). oe_en[b] is high on the sample after byte b's strobe and output enable are both seen low, where bit 1 is the upper byte and bit 0 the lower byte.
- R5: Write enable low at the sample where a byte's strobe falls is an early write. wr_stb[b] pulses once on the next sample, oe_en[b] stays low, and the cycle reports mode 2.
- R6: Write enable falling while a byte's strobe is already low, with no output-enable read earlier in that pulse, is a delayed write. wr_stb[b] pulses once for each byte whose strobe is low, and the cycle reports mode 3.
- R7: When output enable is seen low with write enable high before write enable falls in the same combined pulse, the cycle reports mode 4 (read-modify-write).
- R8: Two or more combined column pulses in one row-strobe low period report the page variant: the base code plus 8 (9 read, 10 early write, 11 delayed write, 12 read-modify-write).
- R9: In a column-first refresh, self_ref goes high once the row strobe has been sampled low SELF_SAMPLES times. The cycle then reports mode 7.
- R10: The combined strobe is active when either line is low. A column-first refresh is therefore detected when only the lower strobe is low as the row strobe falls.
- R11: viol[0] is high for a sample in which output enable is low while a byte is in an early-write data phase.
- R12: viol[1] pulses when the second of the two column strobes falls, or rises after both were low, more than SKEW_MAX samples after the first one did.
- R13: viol[2] pulses when one byte is written early and the other byte is written late within the same combined column pulse.
- R14: mode_valid is a single-sample pulse on the sample after the row strobe is seen rising, and mode holds its value until the next cycle completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| mode | output | 4 | Code of the last completed cycle |
| mode_valid | output | 1 | Pulse when mode is updated |
| wr_stb | output | 2 | Per-byte write pulse, bit 1 upper |
| oe_en | output | 2 | Per-byte output drive enable |
| self_ref | output | 1 | Self-refresh duration reached |
| viol | output | 3 | Violations: 0 OE in early write, 1 strobe skew, 2 mixed write kinds |

## Verification
The assertions assume that the strobes are already synchronous to clk, so each level change is seen on exactly one sample and the row strobe never rises on two consecutive samples. The stimulus holds every input value for a whole clock period and changes it only on the falling clock edge. The skew and self-refresh windows are kept short through parameter overrides, so that the counters reach their limits within a few dozen samples.

// File: rtl/dram_mode_decoder.sv
module dram_mode_decoder #(
  parameter int SELF_SAMPLES = 5000,
  parameter int SKEW_MAX     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       ucas_n,
  input  logic       lcas_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic [3:0] mode,
  output logic       mode_valid,
  output logic [1:0] wr_stb,
  output logic [1:0] oe_en,
  output logic       self_ref,
  output logic [2:0] viol
);
  localparam int CW  = $clog2(SELF_SAMPLES + 1);
  localparam int SKW = $clog2(SKEW_MAX + 2);
  localparam logic [3:0] M_READ = 4'd1, M_EWR = 4'd2, M_DWR = 4'd3, M_RMW = 4'd4;
  localparam logic [3:0] M_RONLY = 4'd5, M_CBR = 4'd6, M_SELF = 4'd7;

  logic           ras_q, we_q, row_q, cbr_q, both_lo_q;
  logic [1:0]     lo_q, early_q, wdone_q, pc_q;
  logic           pe_q, pl_q, rd_q, prmw_q, ce_q, cl_q, cr_q;
  logic [CW-1:0]  lo_cnt_q;
  logic [SKW-1:0] sk_q;

  wire [1:0] lo       = ~{ucas_n, lcas_n};
  wire       cas_any  = |lo;
  wire       cas_anyq = |lo_q;
  wire       ras_fall = ras_q & ~ras_n;
  wire       ras_rise = ~ras_q & ras_n;
  wire [1:0] bfall    = lo & ~lo_q;
  wire       cas_fall = cas_any & ~cas_anyq;
  wire       we_fall  = we_q & ~we_n;

  wire row_nxt = ras_fall ? ~cas_any : (ras_n ? 1'b0 : row_q);
  wire cbr_nxt = ras_fall ?  cas_any : (ras_n ? 1'b0 : cbr_q);

  logic [1:0] early_nxt;
  always_comb begin
    for (int b = 0; b < 2; b++)
      early_nxt[b] = row_nxt & lo[b] & (bfall[b] ? ~we_n : early_q[b]);
  end

  wire [1:0] wr_early  = bfall & {2{row_nxt & ~we_n}};
  wire [1:0] wr_late   = lo & ~bfall & ~wdone_q & {2{row_nxt & we_fall}};
  wire [1:0] wr_nxt    = wr_early | wr_late;
  wire [1:0] wdone_nxt = lo & {2{row_nxt}} & (wdone_q | wr_nxt);

  wire pulse    = row_nxt & cas_any;
  wire pe_nxt   = pulse & (pe_q | (|wr_early));
  wire pl_nxt   = pulse & (pl_q | (|wr_late));
  wire rd_nxt   = pulse & (rd_q | (~oe_n & we_n & ~pe_nxt));
  wire prmw_nxt = pulse & (prmw_q | ((|wr_late) & rd_q));

  wire ce_nxt = row_nxt & (ce_q | pe_nxt);
  wire cl_nxt = row_nxt & (cl_q | pl_nxt);
  wire cr_nxt = row_nxt & (cr_q | prmw_nxt);
  wire [1:0] pc_nxt = !row_nxt ? 2'd0 :
                      (cas_fall && pc_q != 2'd2) ? pc_q + 2'd1 : pc_q;

  wire [CW-1:0] lo_cnt_nxt = !cbr_nxt ? '0 :
                             (lo_cnt_q == CW'(SELF_SAMPLES)) ? lo_cnt_q : lo_cnt_q + CW'(1);
  assign self_ref = cbr_q & (lo_cnt_q == CW'(SELF_SAMPLES));

  wire mism   = lo[0] ^ lo[1];
  wire mism_q = lo_q[0] ^ lo_q[1];
  wire [SKW-1:0] sk_nxt = !mism ? '0 :
                          (sk_q == SKW'(SKEW_MAX + 1)) ? sk_q : sk_q + SKW'(1);
  wire both_lo_nxt = (&lo) | (cas_any & both_lo_q);

  wire v_skew = mism_q & ~mism & (sk_q > SKW'(SKEW_MAX)) &
                ((&lo) | (~cas_any & both_lo_q));
  wire v_oe   = row_nxt & ~oe_n & (|early_nxt);
  wire v_mix  = pe_nxt & pl_nxt & ~(pe_q & pl_q);

  wire [3:0] base = cr_q ? M_RMW : cl_q ? M_DWR : ce_q ? M_EWR : M_READ;
  wire [3:0] cls  = cbr_q ? (self_ref ? M_SELF : M_CBR) :
                    (pc_q == 2'd0) ? M_RONLY :
                    (pc_q == 2'd1) ? base : (base | 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;  we_q <= 1'b1;  lo_q <= '0;
      row_q <= 1'b0;  cbr_q <= 1'b0; both_lo_q <= 1'b0;
      early_q <= '0;  wdone_q <= '0; pc_q <= '0;
      pe_q <= 1'b0;   pl_q <= 1'b0;  rd_q <= 1'b0; prmw_q <= 1'b0;
      ce_q <= 1'b0;   cl_q <= 1'b0;  cr_q <= 1'b0;
      lo_cnt_q <= '0; sk_q <= '0;
      mode <= '0;     mode_valid <= 1'b0;
      wr_stb <= '0;   oe_en <= '0;   viol <= '0;
    end else begin
      ras_q <= ras_n; we_q <= we_n;  lo_q <= lo;
      row_q <= row_nxt; cbr_q <= cbr_nxt; both_lo_q <= both_lo_nxt;
      early_q <= early_nxt; wdone_q <= wdone_nxt; pc_q <= pc_nxt;
      pe_q <= pe_nxt; pl_q <= pl_nxt; rd_q <= rd_nxt; prmw_q <= prmw_nxt;
      ce_q <= ce_nxt; cl_q <= cl_nxt; cr_q <= cr_nxt;
      lo_cnt_q <= lo_cnt_nxt; sk_q <= sk_nxt;
      mode_valid <= ras_rise & (row_q | cbr_q);
      if (ras_rise && (row_q || cbr_q)) mode <= cls;
      wr_stb <= wr_nxt;
      oe_en  <= {2{row_nxt & ~oe_n}} & lo & ~early_nxt;
      viol   <= {v_mix, v_skew, v_oe};
    end
  end

  // R14
  mode_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> !mode_valid);

  // R14
  mode_valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> mode != 4'd0);

  // R4
  oe_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_en != 2'b00) |-> !$past(ras_n));

  // R5
  wr_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb != 2'b00) |-> !$past(ras_n));

  // R6
  wr_upper_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[1] |-> !$past(ucas_n));

  // R6
  wr_lower_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[0] |-> !$past(lcas_n));
endmodule

// File: tb/tb_dram_mode_decoder.sv
module tb_dram_mode_decoder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ras_n, ucas_n, lcas_n, we_n, oe_n;
  logic [3:0] mode;
  logic mode_valid, self_ref;
  logic [1:0] wr_stb, oe_en;
  logic [2:0] viol;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  dram_mode_decoder #(.SELF_SAMPLES(16), .SKEW_MAX(2)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .mode(mode), .mode_valid(mode_valid),
    .wr_stb(wr_stb), .oe_en(oe_en), .self_ref(self_ref), .viol(viol));

  // {req, ras u l we oe, wr, oe_en, mode_valid, mode, viol}
  localparam int NV = 43;
  localparam logic [20:0] VEC [NV] = '{
    21'b0100_11111_00_00_0_0000_000, // R4 read
    21'b0100_01111_00_00_0_0000_000,
    21'b0100_00011_00_00_0_0000_000,
    21'b0100_00010_00_11_0_0000_000,
    21'b0100_01110_00_00_0_0000_000,
    21'b0100_11111_00_00_1_0001_000,
    21'b1110_11111_00_00_0_0001_000, // R14
    21'b0101_01101_00_00_0_0001_000, // R5 early write
    21'b0101_00001_11_00_0_0001_000,
    21'b0101_00001_00_00_0_0001_000,
    21'b0101_01111_00_00_0_0001_000,
    21'b0101_11111_00_00_1_0010_000,
    21'b0110_01111_00_00_0_0010_000, // R6 delayed write, upper byte
    21'b0110_00111_00_00_0_0010_000,
    21'b0110_00101_10_00_0_0010_000,
    21'b0110_00101_00_00_0_0010_000,
    21'b0110_01111_00_00_0_0010_000,
    21'b0110_11111_00_00_1_0011_000,
    21'b0111_01111_00_00_0_0011_000, // R7 read-modify-write
    21'b0111_00011_00_00_0_0011_000,
    21'b0111_00010_00_11_0_0011_000,
    21'b0111_00001_11_00_0_0011_000,
    21'b0111_01111_00_00_0_0011_000,
    21'b0111_11111_00_00_1_0100_000,
    21'b0011_01111_00_00_0_0100_000, // R3 row-only refresh
    21'b0011_11111_00_00_1_0101_000,
    21'b1010_11011_00_00_0_0101_000, // R10 lower strobe only, then row falls
    21'b1010_01011_00_00_0_0101_000,
    21'b1010_11111_00_00_1_0110_000,
    21'b1000_01111_00_00_0_0110_000, // R8 page read, lower byte
    21'b1000_01011_00_00_0_0110_000,
    21'b1000_01010_00_01_0_0110_000,
    21'b1000_01111_00_00_0_0110_000,
    21'b1000_01011_00_00_0_0110_000,
    21'b1000_01111_00_00_0_0110_000,
    21'b1000_11111_00_00_1_1001_000,
    21'b1000_01101_00_00_0_1001_000, // R8 page early write
    21'b1000_00001_11_00_0_1001_000,
    21'b1000_01101_00_00_0_1001_000,
    21'b1000_00001_11_00_0_1001_000,
    21'b1000_01111_00_00_0_1001_000,
    21'b1000_11111_00_00_1_1010_000,
    21'b1110_11111_00_00_0_1010_000  // R14
  };

  task automatic drive(input logic [4:0] v);
    {ras_n, ucas_n, lcas_n, we_n, oe_n} = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] obs();
    return {wr_stb, oe_en, mode_valid, mode, viol};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {ras_n, ucas_n, lcas_n, we_n, oe_n} = 5'b11111;
    repeat (3) @(negedge clk);
    check("R1 in reset", {obs(), 3'b000} | {11'd0, self_ref}, 12'd0);
    rst_n = 1'b1;
    drive(5'b11111);
    check("R1 after reset", obs(), 12'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16:12]);
      check($sformatf("R%0d step %0d", VEC[i][20:17], i), obs(), VEC[i][11:0]);
    end

    // R2 and R9: 15 low samples stays a plain refresh
    drive(5'b10011);
    for (int i = 0; i < 15; i++) drive(5'b00011);
    check("R9 below limit", {11'd0, self_ref}, 12'd0);
    drive(5'b11111);
    check("R2 short refresh", obs(), 12'b00_00_1_0110_000);
    // R9: 16 low samples reaches self refresh
    drive(5'b10011);
    for (int i = 0; i < 16; i++) drive(5'b00011);
    check("R9 at limit", {11'd0, self_ref}, 12'd1);
    drive(5'b11111);
    check("R9 self refresh code", obs(), 12'b00_00_1_0111_000);

    // R11
    drive(5'b01101);
    drive(5'b00000);
    check("R11 oe during early write", {wr_stb, oe_en, viol}, 7'b11_00_001);
    drive(5'b01111);
    check("R11 cleared", {9'd0, viol}, 12'd0);
    drive(5'b11111);
    check("R5 after R11", {8'd0, mode}, 12'd2);

    // R12: two mismatched samples, within limit
    drive(5'b01111);
    drive(5'b01011);
    drive(5'b01011);
    drive(5'b00011);
    check("R12 skew at limit", {9'd0, viol}, 12'd0);
    drive(5'b01111);
    drive(5'b11111);
    // R12: three mismatched samples on the fall
    drive(5'b01111);
    for (int i = 0; i < 3; i++) drive(5'b01011);
    drive(5'b00011);
    check("R12 fall skew", {9'd0, viol}, 12'd2);
    // R12: three mismatched samples on the rise
    for (int i = 0; i < 3; i++) drive(5'b00111);
    drive(5'b01111);
    check("R12 rise skew", {9'd0, viol}, 12'd2);
    drive(5'b11111);

    // R13
    drive(5'b01111);
    drive(5'b01011);
    drive(5'b01001);
    check("R13 late lower write", {wr_stb, viol}, 5'b01_000);
    drive(5'b00001);
    check("R13 mixed write kinds", {wr_stb, viol}, 5'b10_100);
    drive(5'b01111);
    drive(5'b11111);
    check("R13 cycle code", {8'd0, mode}, 12'd3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule